// File: doc/BRIEF.md
# Multi-Depth Pixel Unpacker with Colour Table

This block sits between a 32-bit video word buffer and the display back end. It takes one word at a time and splits it into pixel indices at a depth chosen at run time: 1, 2, 4 or 8 bits per pixel. Each index passes through a writable 256-entry colour table whose entries are 12-bit RGB values, 4 bits per channel. One colour comes out for each pixel-enable strobe.

The block holds up to two words: the word being unpacked and one waiting behind it. It asks for a new word early, so a prompt supplier keeps the pixel stream free of gaps across word boundaries. The fill state machine has three states. EMPTY means no word is held. RUN means one word is being unpacked. FULL means one word is being unpacked and a second word is waiting.

The transitions are:
- EMPTY to RUN when a word is accepted.
- RUN to FULL when a word is accepted before the last pixel.
- RUN stays in RUN when the last pixel and a new word coincide (the new word loads directly).
- RUN to EMPTY when the last pixel is taken and no word is offered.
- FULL to RUN when the last pixel is taken (the waiting word is promoted).

Software, or any other agent, can rewrite the colour table at any time through a simple write port.

Top module: `pix_unpack_top`

## Requirements
- R1: After reset, word_req is 1, rgb_valid is 0 and rgb_out is 0.
- R2: depth_sel codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bits per pixel. A word then yields 32, 16, 8 or 4 pixels. The depth is captured together with each word when it is accepted, and later changes of depth_sel do not affect a word already held.
- R3: Within a word, byte 0 (bits 7:0) is unpacked first, then bytes 1, 2 and 3. Within each byte, pixels are taken from the most significant bit downward.
- R4: A pixel field narrower than 8 bits is zero-extended to form the table index, so 1, 2 and 4 bpp use only entries 0-1, 0-3 and 0-15.
- R5: A pixel taken in cycle t (pix_en high while a word is held) appears on rgb_out with rgb_valid high in cycle t+1. In cycles with no lookup, rgb_valid is 0 and rgb_out holds its last value.
- R6: word_req is high when no word is held, and high when one word is held with at most two of its pixels left. It is low while a second word waits. A word is accepted in a cycle where word_valid and word_req are both high.
- R7: When the next word is accepted before the current word's last pixel, the first pixel of the next word follows the last pixel of the current word with no idle cycle under continuous pix_en.
- R8: pal_we writes pal_wdata into entry pal_addr at the clock edge. A lookup of that entry in the same cycle returns the old colour, and later lookups return the new one.
- R9: pix_en while no word is held produces no output pixel and consumes nothing.
- R10: word_valid while word_req is low is ignored, and that word never appears in the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| depth_sel | input | 2 | Depth code captured with each accepted word |
| word_valid | input | 1 | A video word is offered |
| word_data | input | 32 | Offered video word |
| word_req | output | 1 | Block can accept a word this cycle |
| pix_en | input | 1 | Pixel strobe |
| pal_we | input | 1 | Colour table write enable |
| pal_addr | input | 8 | Colour table entry to write |
| pal_wdata | input | 12 | RGB value to write, 4 bits per channel |
| rgb_valid | output | 1 | rgb_out carries a new pixel colour |
| rgb_out | output | 12 | Pixel colour |

## Verification
A colour table write and a lookup of the same entry can fall in the same clock. The bench provokes this by raising pal_we for the entry that every byte of an 8 bpp word points at, in the very cycle the first pixel of that word is taken, and by keeping pix_en high afterwards. The scoreboard expects the old colour for that first pixel and the new colour for the three pixels that follow. The second collision is the last pixel of one word coinciding with the promotion of the next. It is provoked by feeding words as soon as word_req rises under continuous pix_en, and it is judged by counting idle output cycles while pixels remain outstanding.

// File: rtl/pix_pkg.sv
package pix_pkg;

    typedef enum logic [1:0] {
        BPP1 = 2'd0,
        BPP2 = 2'd1,
        BPP4 = 2'd2,
        BPP8 = 2'd3
    } bpp_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_RUN   = 2'd1,
        ST_FULL  = 2'd2
    } fill_e;

    // pixels carried by one word at a given depth code
    function automatic int unsigned pix_per_word(int unsigned word_w, bpp_e d);
        return word_w >> d;
    endfunction

endpackage

// File: rtl/pix_word_ctrl.sv
module pix_word_ctrl
    import pix_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int POS_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bpp_e              depth_in,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              pix_en,
    output logic              word_req,
    output logic              take,
    output logic [WORD_W-1:0] cur_word,
    output bpp_e              cur_depth,
    output logic [POS_W-1:0]  pos
);

    fill_e             state, state_d;
    logic [WORD_W-1:0] nxt_word;
    bpp_e              nxt_depth;
    logic [POS_W-1:0]  pos_d;
    logic [POS_W-1:0]  last;
    logic              accept, at_end;
    logic              load_cur, load_nxt, promote;

    always_comb begin
        last = POS_W'(pix_per_word(WORD_W, cur_depth) - 1);
    end

    // output decode
    always_comb begin
        word_req = (state == ST_EMPTY) ||
                   ((state == ST_RUN) && (pos >= last - POS_W'(1)));
        take     = pix_en && (state != ST_EMPTY);
        accept   = word_valid && word_req;
        at_end   = take && (pos == last);
    end

    // next-state logic
    always_comb begin
        state_d  = state;
        pos_d    = pos;
        load_cur = 1'b0;
        load_nxt = 1'b0;
        promote  = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                if (accept) begin
                    state_d  = ST_RUN;
                    load_cur = 1'b1;
                    pos_d    = '0;
                end
            end
            ST_RUN: begin
                if (at_end) begin
                    if (accept) begin
                        load_cur = 1'b1;
                        pos_d    = '0;
                    end else begin
                        state_d = ST_EMPTY;
                    end
                end else begin
                    if (take)
                        pos_d = pos + POS_W'(1);
                    if (accept) begin
                        state_d  = ST_FULL;
                        load_nxt = 1'b1;
                    end
                end
            end
            ST_FULL: begin
                if (at_end) begin
                    state_d = ST_RUN;
                    promote = 1'b1;
                    pos_d   = '0;
                end else if (take) begin
                    pos_d = pos + POS_W'(1);
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
            pos   <= '0;
        end else begin
            state <= state_d;
            pos   <= pos_d;
        end
    end

    // word slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_word  <= '0;
            cur_depth <= BPP1;
            nxt_word  <= '0;
            nxt_depth <= BPP1;
        end else begin
            if (load_cur) begin
                cur_word  <= word_data;
                cur_depth <= depth_in;
            end else if (promote) begin
                cur_word  <= nxt_word;
                cur_depth <= nxt_depth;
            end
            if (load_nxt) begin
                nxt_word  <= word_data;
                nxt_depth <= depth_in;
            end
        end
    end

    // R6
    full_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL) |-> !word_req);

    // R10
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && !take) |=> (state == ST_FULL) && $stable(cur_word));

    // R2
    pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EMPTY) |-> (pos <= last));

    // R7
    gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && at_end) |=> (state == ST_RUN) && (pos == '0));

    // R9
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && at_end && !word_valid) |=> (state == ST_EMPTY));

endmodule

// File: rtl/pix_index_sel.sv
module pix_index_sel
    import pix_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int POS_W  = $clog2(WORD_W),
    parameter int IDX_W  = 8
) (
    input  logic [WORD_W-1:0] word,
    input  bpp_e              depth,
    input  logic [POS_W-1:0]  pos,
    output logic [IDX_W-1:0]  index
);

    localparam int N_DEPTH = 4;

    logic [7:0] cands [N_DEPTH];

    for (genvar g = 0; g < N_DEPTH; g++) begin : g_depth
        localparam int BPP = 1 << g;
        logic [POS_W-1:0] bitpos;
        logic [7:0]       sel_byte;
        logic [2:0]       shamt;
        always_comb begin
            bitpos   = POS_W'(32'(pos) * BPP);
            sel_byte = 8'(word >> {bitpos[POS_W-1:3], 3'b000});
            shamt    = 3'(8 - BPP) - bitpos[2:0];
            cands[g] = (sel_byte >> shamt) & 8'((1 << BPP) - 1);
        end
    end

    always_comb begin
        index = IDX_W'(cands[depth]);
    end

endmodule

// File: rtl/pix_palette.sv
module pix_palette #(
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [IDX_W-1:0]   waddr,
    input  logic [COLOR_W-1:0] wdata,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   raddr,
    output logic               rgb_valid,
    output logic [COLOR_W-1:0] rgb_out
);

    localparam int DEPTH = 1 << IDX_W;

    logic [COLOR_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rgb_valid <= 1'b0;
            rgb_out   <= '0;
        end else begin
            rgb_valid <= rd_en;
            if (rd_en)
                rgb_out <= mem[raddr];
        end
    end

    // R5
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rgb_valid);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rgb_valid && $stable(rgb_out));

    // R8
    write_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(we) && rd_en && raddr == $past(waddr)) |=> (rgb_out == $past(wdata, 2)));

endmodule

// File: rtl/pix_unpack_top.sv
module pix_unpack_top
    import pix_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int IDX_W   = 8,
    parameter int COLOR_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         depth_sel,
    input  logic               word_valid,
    input  logic [WORD_W-1:0]  word_data,
    output logic               word_req,
    input  logic               pix_en,
    input  logic               pal_we,
    input  logic [IDX_W-1:0]   pal_addr,
    input  logic [COLOR_W-1:0] pal_wdata,
    output logic               rgb_valid,
    output logic [COLOR_W-1:0] rgb_out
);

    localparam int POS_W = $clog2(WORD_W);

    logic              take;
    logic [WORD_W-1:0] cur_word;
    bpp_e              cur_depth;
    logic [POS_W-1:0]  pos;
    logic [IDX_W-1:0]  pix_idx;

    pix_word_ctrl #(.WORD_W(WORD_W), .POS_W(POS_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .depth_in   (bpp_e'(depth_sel)),
        .word_valid (word_valid),
        .word_data  (word_data),
        .pix_en     (pix_en),
        .word_req   (word_req),
        .take       (take),
        .cur_word   (cur_word),
        .cur_depth  (cur_depth),
        .pos        (pos)
    );

    pix_index_sel #(.WORD_W(WORD_W), .POS_W(POS_W), .IDX_W(IDX_W)) u_sel (
        .word  (cur_word),
        .depth (cur_depth),
        .pos   (pos),
        .index (pix_idx)
    );

    pix_palette #(.IDX_W(IDX_W), .COLOR_W(COLOR_W)) u_pal (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (pal_we),
        .waddr     (pal_addr),
        .wdata     (pal_wdata),
        .rd_en     (take),
        .raddr     (pix_idx),
        .rgb_valid (rgb_valid),
        .rgb_out   (rgb_out)
    );

    // R4
    narrow1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cur_depth == BPP1) |-> (pix_idx[IDX_W-1:1] == '0));

    // R4
    narrow4_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cur_depth == BPP4) |-> (pix_idx[IDX_W-1:4] == '0));

endmodule

// File: tb/pix_unpack_top_bench.sv
module pix_unpack_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  depth_sel = 2'd0;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_req;
    logic        pix_en = 1'b0;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_addr = '0;
    logic [11:0] pal_wdata = '0;
    logic        rgb_valid;
    logic [11:0] rgb_out;

    always #10 clk = ~clk;

    pix_unpack_top u_pix_unpack_top (
        .clk(clk), .rst_n(rst_n), .depth_sel(depth_sel),
        .word_valid(word_valid), .word_data(word_data), .word_req(word_req),
        .pix_en(pix_en), .pal_we(pal_we), .pal_addr(pal_addr),
        .pal_wdata(pal_wdata), .rgb_valid(rgb_valid), .rgb_out(rgb_out)
    );

    int checks = 0;
    int fails  = 0;
    int gaps   = 0;
    int unexpected = 0;
    bit gap_arm = 0;
    bit seen_v  = 0;
    logic [11:0] last_rgb = '0;
    logic [11:0] pal_m [256];
    logic [11:0] exp_q [$];
    string       tag_q [$];

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pix_of(logic [31:0] w, int d, int k);
        int bits = 1 << d;
        int p    = k * bits;
        logic [7:0] by = w[8*(p/8) +: 8];
        return 8'((by >> (8 - (p % 8) - bits)) & ((1 << bits) - 1));
    endfunction

    task automatic push_word(logic [31:0] w, int d);
        for (int k = 0; k < (32 >> d); k++) begin
            exp_q.push_back(pal_m[pix_of(w, d, k)]);
            tag_q.push_back(d == 3 ? "R2/R3 8bpp" : "R2/R3/R4 narrow");
        end
    endtask

    // caller is at a negedge
    task automatic feed(logic [31:0] w, int d, bit push);
        while (!word_req) @(negedge clk);
        word_valid = 1'b1;
        word_data  = w;
        depth_sel  = 2'(d);
        if (push) push_word(w, d);
        @(negedge clk);
        word_valid = 1'b0;
        depth_sel  = ~2'(d);
    endtask

    task automatic pulse();
        pix_en = 1'b1;
        @(negedge clk);
        pix_en = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (gap_arm) begin
                if (rgb_valid) seen_v = 1;
                else if (seen_v && exp_q.size() > 0) gaps++;
            end
            if (rgb_valid) begin
                if (exp_q.size() == 0) begin
                    unexpected++;
                    chk(0, "R9/R10 unexpected pixel", 32'(rgb_out), 32'h0);
                end else begin
                    logic [11:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rgb_out == e, t, 32'(rgb_out), 32'(e));
                end
                last_rgb = rgb_out;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk(word_req == 1'b1, "R1 word_req", 32'(word_req), 32'h1);
        chk(rgb_valid == 1'b0, "R1 rgb_valid", 32'(rgb_valid), 32'h0);
        chk(rgb_out == 12'h0, "R1 rgb_out", 32'(rgb_out), 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < 256; i++) begin
            pal_we    = 1'b1;
            pal_addr  = 8'(i);
            pal_wdata = 12'((i * 37 + 5) ^ (i << 4));
            pal_m[i]  = pal_wdata;
            @(negedge clk);
        end
        pal_we = 1'b0;

        // R2 R3 R4 R7: continuous stream, mixed depths
        gap_arm = 1;
        pix_en  = 1'b1;
        feed(32'hA1B2C3D4, 3, 1);
        feed(32'h0F1E2D3C, 2, 1);
        feed(32'h96C35A0F, 1, 1);
        feed(32'hF0E18421, 0, 1);
        feed(32'h12345678, 3, 1);
        feed(32'h80000001, 0, 1);
        drain();
        gap_arm = 0;
        chk(gaps == 0, "R7 idle cycles in stream", 32'(gaps), 32'h0);

        // R9 R5: strobes with no word held
        repeat (6) begin
            @(negedge clk);
            chk(rgb_valid == 1'b0, "R9 no pixel when empty", 32'(rgb_valid), 32'h0);
            chk(rgb_out == last_rgb, "R5 rgb_out holds", 32'(rgb_out), 32'(last_rgb));
        end
        pix_en = 1'b0;

        // R5 R6 R10
        feed(32'h01020304, 3, 1);
        pulse();
        chk(rgb_valid == 1'b1, "R5 one-cycle latency", 32'(rgb_valid), 32'h1);
        chk(word_req == 1'b0, "R6 req low with 3 left", 32'(word_req), 32'h0);
        @(negedge clk);
        chk(rgb_valid == 1'b0, "R5 valid drops when idle", 32'(rgb_valid), 32'h0);
        pulse();
        chk(word_req == 1'b1, "R6 req high with 2 left", 32'(word_req), 32'h1);
        feed(32'h05060708, 3, 1);
        chk(word_req == 1'b0, "R6 req low when full", 32'(word_req), 32'h0);
        word_valid = 1'b1;
        word_data  = 32'hDEADBEEF;
        depth_sel  = 2'd0;
        repeat (3) @(negedge clk);
        word_valid = 1'b0;
        pix_en = 1'b1;
        drain();
        repeat (5) @(negedge clk);
        pix_en = 1'b0;
        chk(unexpected == 0, "R10 offered word ignored", 32'(unexpected), 32'h0);

        // R8: write and lookup of the same entry in one cycle
        feed(32'h10101010, 3, 0);
        exp_q.push_back(pal_m[16]);  tag_q.push_back("R8 old colour same cycle");
        repeat (3) begin
            exp_q.push_back(12'h5A5); tag_q.push_back("R8 new colour after write");
        end
        pix_en    = 1'b1;
        pal_we    = 1'b1;
        pal_addr  = 8'h10;
        pal_wdata = 12'h5A5;
        @(negedge clk);
        pal_we    = 1'b0;
        pal_m[16] = 12'h5A5;
        drain();
        @(negedge clk);
        pix_en = 1'b0;
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all pixels seen", 32'(exp_q.size()), 32'h0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule